// File: doc/BRIEF.md
# Programmable square-wave and periodic-tick divider

This block divides a 32.768 kHz timebase into a selectable square wave and a periodic tick. The timebase arrives as a one-cycle enable pulse in the system clock domain. Each pulse advances a 15-stage binary ripple-style counter. Bit k of that counter toggles at 32768 / 2^(k+1) Hz. A 4-bit rate code picks one of thirteen counter bits, bits 1 through 13, as the active tap.

The tap level drives the square-wave pin. A separate enable gates that pin, and a supply-fail input forces it low. The periodic tick is a single system-clock pulse each time the selected tap goes from 0 to 1. Its period is therefore one full square-wave cycle. The tick does not depend on the square-wave enable or on the supply-fail input.

The mapping from code to tap is not monotonic:

| Rate code | Tap bit | Square-wave frequency |
|-----------|---------|-----------------------|
| 3 to 7 | 1 to 5 | 8.192 kHz down to 512 Hz |
| 1 and 8 | 6 | 256 Hz |
| 2 and 9 | 7 | 128 Hz |
| 10 to 15 | 8 to 13 | 64 Hz down to 2 Hz |

A new rate code takes effect without clearing the counter.

Top module: `sqw_div_gen`

## Requirements
- R1: A synchronous active-high reset clears every counter stage. The square-wave output and the tick read 0 after the reset edge.
- R2: The counter advances by exactly one on each clock edge that samples `tb_step` high, and holds otherwise. It is 15 bits wide and wraps from 32767 to 0. With no step, the outputs do not change and no tick occurs.
- R3: Rate code 0 holds the square-wave output low and produces no tick.
- R4: Rate codes 1 and 8 both select counter bit 6 (256 Hz, tick every 128 steps). Codes 2 and 9 both select bit 7 (128 Hz, tick every 256 steps).
- R5: Rate codes 3, 4, 5, 6 and 7 select counter bits 1, 2, 3, 4 and 5.
- R6: Rate codes 10 to 15 select counter bits 8 to 13. Code 15 gives 2 Hz, with one tick per 16384 steps.
- R7: The square-wave output is registered. One clock after the counter changes, it equals the selected bit of the counter when the gating inputs allow it.
- R8: The tick is high for exactly one clock, in the same cycle in which the square-wave output could first show the tap's new 1. It fires exactly when the selected bit has just gone from 0 to 1, that is, when the step count modulo 2^(k+1) equals 2^k.
- R9: While `sqw_enable` is 0, the square-wave output is 0. Ticks continue unchanged.
- R10: While `supply_fail` is 1, the square-wave output is 0. Ticks continue unchanged.
- R11: Changing the rate code does not clear or disturb the counter. A code change by itself never produces a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_step | input | 1 | One-cycle timebase enable at 32.768 kHz |
| rate_code | input | 4 | Rate code selecting the tap |
| sqw_enable | input | 1 | Square-wave output enable |
| supply_fail | input | 1 | Supply-fail inhibit; forces the square wave low |
| sqw_out | output | 1 | Registered square-wave output |
| periodic_tick | output | 1 | One-cycle pulse per tap period |

## Verification
The bench keeps its own count of timebase steps and predicts both outputs from the code table after every step. This catches a design that treats the code as a plain shift amount, because such a design would put codes 1, 2 and 3 to 7 on the wrong bits. It also catches a design that aliases codes 8 and 9 incorrectly.

Several scenarios target specific faults:
- Code switches in the middle of a run expose a design that clears the counter on a switch, or that fires a tick from an edge detector carried over from the old tap.
- Runs with the gate inputs low expose a design that also suppresses the tick.
- A full wrap of the counter and a reset in the middle of a run expose a counter of the wrong width and an incomplete reset.
- Tick counts over whole periods of the slowest setting expose ticks that repeat or fire at the wrong step.

// File: rtl/sqwdiv_pkg.sv
package sqwdiv_pkg;

  localparam int STAGES = 15;
  localparam int SEL_W  = 4;
  localparam int IDX_W  = $clog2(STAGES);

  typedef struct packed {
    logic             on;
    logic [IDX_W-1:0] idx;
  } tap_t;

  // Rate code to tap: codes 1/2 alias onto the same taps as 8/9,
  // codes 3..15 walk up the chain from bit 1.
  function automatic tap_t map_code(input logic [SEL_W-1:0] code);
    tap_t t;
    t.on = (code != '0);
    if (code == '0)
      t.idx = '0;
    else if (code == SEL_W'(1) || code == SEL_W'(2))
      t.idx = IDX_W'(code + SEL_W'(5));
    else
      t.idx = IDX_W'(code - SEL_W'(2));
    return t;
  endfunction

endpackage

// File: rtl/sqwdiv_chain.sv
module sqwdiv_chain #(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [STAGES-1:0] count,
  output logic              stepped
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      stepped <= 1'b0;
    end else begin
      stepped <= step;
      if (step) count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sqwdiv_tapsel.sv
module sqwdiv_tapsel
  import sqwdiv_pkg::*;
#(
  parameter int STAGES = sqwdiv_pkg::STAGES
) (
  input  logic [SEL_W-1:0]  code,
  input  logic [STAGES-1:0] count,
  output logic              level,
  output logic              rise_now
);

  // rise_vec[i]: bit i is 1 and every lower bit is 0, i.e. bit i has
  // just turned on if the counter advanced on the previous edge.
  logic [STAGES-1:0] rise_vec;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_rise
      if (gi == 0) begin : g_lsb
        assign rise_vec[gi] = count[gi];
      end else begin : g_up
        assign rise_vec[gi] = count[gi] & ~(|count[gi-1:0]);
      end
    end
  endgenerate

  tap_t tap;

  always_comb begin
    tap      = map_code(code);
    level    = tap.on & count[tap.idx];
    rise_now = tap.on & rise_vec[tap.idx];
  end

endmodule

// File: rtl/sqwdiv_out.sv
module sqwdiv_out (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic rise_now,
  input  logic stepped,
  input  logic gate_en,
  input  logic inhibit,
  output logic sqw_q,
  output logic tick_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sqw_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      sqw_q  <= level & gate_en & ~inhibit;
      tick_q <= rise_now & stepped;
    end
  end

endmodule

// File: rtl/sqw_div_gen.sv
module sqw_div_gen
  import sqwdiv_pkg::*;
#(
  parameter int STAGES = sqwdiv_pkg::STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tb_step,
  input  logic [SEL_W-1:0] rate_code,
  input  logic             sqw_enable,
  input  logic             supply_fail,
  output logic             sqw_out,
  output logic             periodic_tick
);

  logic [STAGES-1:0] count;
  logic              stepped;
  logic              level;
  logic              rise_now;

  sqwdiv_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .step    (tb_step),
    .count   (count),
    .stepped (stepped)
  );

  sqwdiv_tapsel #(.STAGES(STAGES)) u_tapsel (
    .code     (rate_code),
    .count    (count),
    .level    (level),
    .rise_now (rise_now)
  );

  sqwdiv_out u_out (
    .clk      (clk),
    .rst      (rst),
    .level    (level),
    .rise_now (rise_now),
    .stepped  (stepped),
    .gate_en  (sqw_enable),
    .inhibit  (supply_fail),
    .sqw_q    (sqw_out),
    .tick_q   (periodic_tick)
  );

endmodule

// File: rtl/sqw_div_gen_chk.sv
module sqw_div_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       tb_step,
  input logic [3:0] rate_code,
  input logic       sqw_enable,
  input logic       supply_fail,
  input logic       sqw_out,
  input logic       periodic_tick
);

  // R1: reset edge leaves both outputs low
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sqw_out && !periodic_tick));

  // R3: code 0 on the previous edge means quiet outputs now
  a_r3_off_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(rate_code) == 4'd0) |-> (!sqw_out && !periodic_tick));

  // R8: tick never lasts two cycles
  a_r8_tick_single: assert property (@(posedge clk) disable iff (rst)
    periodic_tick |=> !periodic_tick);

  // R2, R11: a tick needs a timebase step two edges earlier
  a_r2_tick_needs_step: assert property (@(posedge clk) disable iff (rst)
    periodic_tick |-> $past(tb_step, 2));

  // R9: disabled square wave stays low
  a_r9_enable_gates: assert property (@(posedge clk) disable iff (rst)
    !$past(sqw_enable) |-> !sqw_out);

  // R10: supply fail holds square wave low
  a_r10_fail_inhibits: assert property (@(posedge clk) disable iff (rst)
    $past(supply_fail) |-> !sqw_out);

endmodule

bind sqw_div_gen sqw_div_gen_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .tb_step       (tb_step),
  .rate_code     (rate_code),
  .sqw_enable    (sqw_enable),
  .supply_fail   (supply_fail),
  .sqw_out       (sqw_out),
  .periodic_tick (periodic_tick)
);

// File: tb/sqw_div_gen_bench.sv
`timescale 1ns/1ps
module sqw_div_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tb_step = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       sqw_enable = 1'b1;
  logic       supply_fail = 1'b0;
  logic       sqw_out;
  logic       periodic_tick;

  int checks = 0;
  int errors = 0;
  int n = 0;          // model step count, modulo 32768
  int ticks_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sqw_div_gen u_sqw_div_gen (
    .clk           (clk),
    .rst           (rst),
    .tb_step       (tb_step),
    .rate_code     (rate_code),
    .sqw_enable    (sqw_enable),
    .supply_fail   (supply_fail),
    .sqw_out       (sqw_out),
    .periodic_tick (periodic_tick)
  );

  // Code table from the requirements (R3..R6); -1 means off.
  function automatic int exp_tap(input logic [3:0] c);
    case (c)
      4'd0:  return -1;
      4'd1:  return 6;
      4'd2:  return 7;
      4'd3:  return 1;
      4'd4:  return 2;
      4'd5:  return 3;
      4'd6:  return 4;
      4'd7:  return 5;
      4'd8:  return 6;
      4'd9:  return 7;
      4'd10: return 8;
      4'd11: return 9;
      4'd12: return 10;
      4'd13: return 11;
      4'd14: return 12;
      default: return 13;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (step count %0d, code %0d)",
               req, act, exp, n, rate_code);
    end
  endtask

  function automatic int model_sqw();
    int k = exp_tap(rate_code);
    if (k < 0 || !sqw_enable || supply_fail) return 0;
    return (n >> k) & 1;
  endfunction

  function automatic int model_tick();
    int k = exp_tap(rate_code);
    if (k < 0) return 0;
    return ((n % (1 << (k + 1))) == (1 << k)) ? 1 : 0;
  endfunction

  // Entered and left at a falling edge; one timebase step, then compare.
  task automatic step_once(input string req);
    tb_step = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tb_step = 1'b0;
    n = (n + 1) % 32768;
    check({req, "/R8 no early tick"}, periodic_tick, 0);
    @(posedge clk);
    @(negedge clk);
    check({req, " sqw"}, sqw_out, model_sqw());
    check({req, " tick"}, periodic_tick, model_tick());
    if (periodic_tick) ticks_seen++;
  endtask

  task automatic run_steps(input string req, input int cnt);
    for (int i = 0; i < cnt; i++) step_once(req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset sqw", sqw_out, 0);
    check("R1 reset tick", periodic_tick, 0);
    rst = 1'b0;
    n = 0;
  endtask

  task automatic t_off();
    rate_code = 4'd0;
    ticks_seen = 0;
    run_steps("R3 code0", 300);
    check("R3 no ticks with code 0", ticks_seen, 0);
  endtask

  task automatic t_fast();
    for (int c = 3; c <= 7; c++) begin
      rate_code = 4'(c);
      run_steps("R5 fast tap", 100);
    end
    rate_code = 4'd3;
    ticks_seen = 0;
    run_steps("R7 code3", 64);
    check("R8 ticks in 64 steps at bit1", ticks_seen, 16);
  endtask

  task automatic t_alias();
    rate_code = 4'd1;
    ticks_seen = 0;
    run_steps("R4 code1", 256);
    check("R4 code1 ticks per 256 steps", ticks_seen, 2);
    rate_code = 4'd8;
    ticks_seen = 0;
    run_steps("R4 code8", 256);
    check("R4 code8 ticks per 256 steps", ticks_seen, 2);
    rate_code = 4'd2;
    ticks_seen = 0;
    run_steps("R4 code2", 256);
    check("R4 code2 ticks per 256 steps", ticks_seen, 1);
    rate_code = 4'd9;
    ticks_seen = 0;
    run_steps("R4 code9", 256);
    check("R4 code9 ticks per 256 steps", ticks_seen, 1);
  endtask

  task automatic t_slow();
    for (int c = 10; c <= 13; c++) begin
      rate_code = 4'(c);
      run_steps("R6 slow tap", 600);
    end
    rate_code = 4'd14;
    run_steps("R6 code14", 8192);
    rate_code = 4'd15;
    ticks_seen = 0;
    run_steps("R6 code15", 16384);
    check("R6 code15 ticks per 16384 steps", ticks_seen, 1);
  endtask

  task automatic t_gate();
    rate_code = 4'd4;
    sqw_enable = 1'b0;
    ticks_seen = 0;
    run_steps("R9 disabled", 64);
    check("R9 ticks continue while disabled", ticks_seen, 8);
    sqw_enable = 1'b1;
    supply_fail = 1'b1;
    ticks_seen = 0;
    run_steps("R10 supply fail", 64);
    check("R10 ticks continue during supply fail", ticks_seen, 8);
    supply_fail = 1'b0;
    run_steps("R10 recovered", 16);
  endtask

  task automatic t_hold();
    int s0;
    rate_code = 4'd3;
    run_steps("R2 prep", 3);
    s0 = sqw_out;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R2 hold sqw without step", sqw_out, s0);
      check("R2 no tick without step", periodic_tick, 0);
    end
  endtask

  task automatic t_switch();
    rate_code = 4'd7;
    run_steps("R11 before switch", 37);
    for (int c = 1; c <= 15; c++) begin
      rate_code = 4'(c);
      @(posedge clk);
      @(negedge clk);
      check("R11 no tick from code change", periodic_tick, 0);
      @(posedge clk);
      @(negedge clk);
      check("R11 sqw after switch, counter kept", sqw_out, model_sqw());
      run_steps("R11 after switch", 5);
    end
  endtask

  task automatic t_wrap();
    rate_code = 4'd15;
    while (n != 32760) step_once("R2 to wrap");
    run_steps("R2 wrap", 100);
    check("R2 count wrapped", (n < 200) ? 1 : 0, 1);
  endtask

  task automatic t_reset_mid();
    rate_code = 4'd3;
    run_steps("R1 before mid reset", 3);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid reset sqw", sqw_out, 0);
    check("R1 mid reset tick", periodic_tick, 0);
    rst = 1'b0;
    n = 0;
    run_steps("R1 after mid reset", 12);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_off();
    t_fast();
    t_alias();
    t_gate();
    t_hold();
    t_switch();
    t_slow();
    t_wrap();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule